// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

A clocked controller that turns single-beat host requests into read and write cycles on an asynchronous static RAM built from four byte-wide lanes of 512K locations each. Every lane has its own active-low select and active-low write strobe. The lanes share one 19-bit location address and one active-low output enable. The host asks for a transfer by holding a request level together with a byte address, write data, byte strobes and a direction flag. The controller answers with a single-cycle acknowledge, and for reads it returns the captured data at the same time.

A two-bit mode input chooses how the lanes are grouped. In the word mode all four lanes form a single 32-bit bank. In the half-word mode lanes 0 and 1 form one 16-bit bank and lanes 2 and 3 form another. In the byte mode each lane is its own 8-bit bank. The mode also decides how the host byte address is split into a lane address and a bank number. The length of each bus phase, in clock cycles, is worked out from nanosecond minimums and the clock period, all given as parameters. Every cycle of a write keeps the output enable high. After a read, the bus always rests for a turnaround gap before the next cycle starts.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no request, every select, every write strobe and the output enable are high (inactive), the data drive enable is low and the acknowledge is low.
- R2: Mode 0 (word): the location address is host address bits [20:2], all four selects go low, lane k carries host data byte k, and on a write lane k's strobe goes low only if byte strobe bit k is set. On a read, all 32 bits of data are returned.
- R3: Mode 1 (half-word): the location address is host address bits [19:1] and host address bit 20 picks the bank. Bank 0 is lanes 0 and 1; bank 1 is lanes 2 and 3. Only that pair is selected. The even lane carries host byte 0 and is strobed by byte strobe bit 0. The odd lane carries host byte 1 and is strobed by byte strobe bit 1. Read data returns in bits [15:0], and bits [31:16] are zero.
- R4: Modes 2 and 3 (byte): the location address is host address bits [18:0]. Host address bits [20:19] pick the single selected lane. That lane carries host byte 0 and is strobed by byte strobe bit 0. Read data returns in bits [7:0], and bits [31:8] are zero.
- R5: A write strobe goes low only on a selected lane whose byte strobe is set. A write whose relevant byte strobes are all clear leaves the memory contents unchanged.
- R6: A write runs as three phases: setup (select low, strobe high), pulse (strobe low) and hold (strobe high, select still low, data still driven). At the default parameters (20 ns clock) the acknowledge appears 4 cycles after the accepting edge.
- R7: The output enable stays high for the whole of every write. The data drive enable is high only during the pulse and hold phases, and never while the output enable is low.
- R8: A read holds the bank's selects and the output enable low for the access phase and captures data at its end. At the default parameters the acknowledge appears 3 cycles after the accepting edge.
- R9: The acknowledge is high for exactly one cycle, and the read data stays unchanged after it.
- R10: After a read, the output enable is high for at least one cycle before any write strobe goes low. No request is accepted while a cycle is in progress or while the acknowledge is high.
- R11: The location address stays stable for as long as any select is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Lane grouping: 0 word, 1 half-word, 2 or 3 byte |
| req_i | input | 1 | Request level, held until acknowledge |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 21 | Host byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte strobes |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid with acknowledge |
| mem_addr_o | output | 19 | Shared location address |
| mem_cs_n_o | output | 4 | Per-lane active-low select |
| mem_we_n_o | output | 4 | Per-lane active-low write strobe |
| mem_oe_n_o | output | 1 | Shared active-low output enable |
| mem_dq_o | output | 32 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 32 | Data returned by the memory |

## Verification
The assertions take for granted that the host holds the request and all its fields steady from raising the request until the acknowledge, and that the mode does not change while a cycle is in progress. The stimulus always drops the request on the cycle the acknowledge is seen and drives new fields only while the request is low or at that same point. The memory model answers only while a lane is selected with output enable low and write strobe high, and it stores a byte on the rising edge of a lane's strobe. Random requests mix all modes over a small window of addresses, so that reads hit locations written in other modes.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4,
    ST_RTURN  = 3'd5
  } phase_e;

  // Cycle count covering a duration, never less than one.
  function automatic int cyc_ceil(input int dur_ps, input int clk_ps);
    int n;
    n = (dur_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_addr_map.sv
module sram_addr_map #(
  parameter int LANES   = 4,
  parameter int BYTE_W  = 8,
  parameter int LANE_AW = 19,
  localparam int DATA_W  = LANES * BYTE_W,
  localparam int HOST_AW = LANE_AW + 2
) (
  input  logic [1:0]         mode,
  input  logic [HOST_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [LANES-1:0]   be,
  output logic [LANE_AW-1:0] lane_addr,
  output logic [LANES-1:0]   sel,
  output logic [LANES-1:0]   wen,
  output logic [DATA_W-1:0]  lane_wdata
);

  logic is32, is16, is8;
  assign is32 = (mode == 2'd0);
  assign is16 = (mode == 2'd1);
  assign is8  = !is32 && !is16;

  always_comb begin
    if (is32)      lane_addr = addr[HOST_AW-1:2];
    else if (is16) lane_addr = addr[HOST_AW-2:1];
    else           lane_addr = addr[LANE_AW-1:0];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int          HALF = l % 2;
    localparam logic        GRP  = 1'((l / 2) % 2);
    localparam logic [1:0]  LID  = 2'(l);

    assign sel[l] = is32
                  | (is16 & (addr[HOST_AW-1] == GRP))
                  | (is8  & (addr[HOST_AW-1 -: 2] == LID));

    assign wen[l] = sel[l] & (is32 ? be[l] : (is16 ? be[HALF] : be[0]));

    assign lane_wdata[l*BYTE_W +: BYTE_W] =
        is32 ? wdata[l*BYTE_W +: BYTE_W] :
        (is16 ? wdata[HALF*BYTE_W +: BYTE_W] : wdata[BYTE_W-1:0]);
  end

  // R4: byte mode selects exactly one lane
  always_comb begin
    a_byte_onehot_r4: assert (!is8 || $onehot(sel));
  end

endmodule

// File: rtl/sram_rd_align.sv
module sram_rd_align #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [1:0]        mode,
  input  logic [1:0]        bank,
  input  logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    if (mode == 2'd0) begin
      rdata = dq;
    end else if (mode == 2'd1) begin
      rdata[HALF_W-1:0] = bank[1] ? dq[DATA_W-1:HALF_W] : dq[HALF_W-1:0];
    end else begin
      rdata[BYTE_W-1:0] = dq[bank*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R6: an expired phase counter does not wrap around
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int BYTE_W     = 8,
  parameter int LANE_AW    = 19,
  parameter int T_CLK_PS   = 20000,
  parameter int T_ASU_PS   = 2000,
  parameter int T_WP_PS    = 12000,
  parameter int T_DSU_PS   = 9000,
  parameter int T_DHD_PS   = 2000,
  parameter int T_WCYC_PS  = 20000,
  parameter int T_ACC_PS   = 25000,
  parameter int T_TURN_PS  = 10000,
  localparam int DATA_W  = LANES * BYTE_W,
  localparam int HOST_AW = LANE_AW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [LANES-1:0]   be_i,
  output logic               ack_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [LANE_AW-1:0] mem_addr_o,
  output logic [LANES-1:0]   mem_cs_n_o,
  output logic [LANES-1:0]   mem_we_n_o,
  output logic               mem_oe_n_o,
  output logic [DATA_W-1:0]  mem_dq_o,
  output logic               mem_dq_oe_o,
  input  logic [DATA_W-1:0]  mem_dq_i
);

  localparam int SU_C  = cyc_ceil(T_ASU_PS, T_CLK_PS);
  localparam int PW_C  = imax(cyc_ceil(T_WP_PS, T_CLK_PS), cyc_ceil(T_DSU_PS, T_CLK_PS));
  localparam int HD_C  = imax(cyc_ceil(T_DHD_PS, T_CLK_PS),
                              cyc_ceil(T_WCYC_PS, T_CLK_PS) - SU_C - PW_C);
  localparam int AC_C  = cyc_ceil(T_ACC_PS, T_CLK_PS);
  localparam int TN_C  = cyc_ceil(T_TURN_PS, T_CLK_PS);
  localparam int CNT_W = $clog2(SU_C + PW_C + HD_C + AC_C + TN_C + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // Phase state
  phase_e state_q, state_d;
  logic   capture, rd_cap, ack_d, ack_q;
  logic   tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    rd_cap  = 1'b0;
    ack_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i && !ack_q) begin
        capture = 1'b1;
        state_d = we_i ? ST_WSETUP : ST_RACC;
      end
      ST_WSETUP: if (tmr_zero) state_d = ST_WPULSE;
      ST_WPULSE: if (tmr_zero) state_d = ST_WHOLD;
      ST_WHOLD:  if (tmr_zero) begin
        state_d = ST_IDLE;
        ack_d   = 1'b1;
      end
      ST_RACC:   if (tmr_zero) begin
        state_d = ST_RTURN;
        rd_cap  = 1'b1;
        ack_d   = 1'b1;
      end
      ST_RTURN:  if (tmr_zero) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_WSETUP: tmr_val = CNT_W'(SU_C - 1);
      ST_WPULSE: tmr_val = CNT_W'(PW_C - 1);
      ST_WHOLD:  tmr_val = CNT_W'(HD_C - 1);
      ST_RACC:   tmr_val = CNT_W'(AC_C - 1);
      ST_RTURN:  tmr_val = CNT_W'(TN_C - 1);
      default:   tmr_val = '0;
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  // Latched request fields
  logic [1:0]         mode_q;
  logic [HOST_AW-1:0] addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   be_q;
  logic [1:0]         fld_mode;
  logic [HOST_AW-1:0] fld_addr;
  logic [DATA_W-1:0]  fld_wdata;
  logic [LANES-1:0]   fld_be;

  always_ff @(posedge clk) begin
    if (capture) begin
      mode_q  <= mode_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  assign fld_mode  = capture ? mode_i  : mode_q;
  assign fld_addr  = capture ? addr_i  : addr_q;
  assign fld_wdata = capture ? wdata_i : wdata_q;
  assign fld_be    = capture ? be_i    : be_q;

  logic [LANE_AW-1:0] map_addr;
  logic [LANES-1:0]   map_sel, map_wen;
  logic [DATA_W-1:0]  map_wdata;

  sram_addr_map #(.LANES(LANES), .BYTE_W(BYTE_W), .LANE_AW(LANE_AW)) u_map (
    .mode       (fld_mode),
    .addr       (fld_addr),
    .wdata      (fld_wdata),
    .be         (fld_be),
    .lane_addr  (map_addr),
    .sel        (map_sel),
    .wen        (map_wen),
    .lane_wdata (map_wdata)
  );

  // Registered memory-side controls, derived from the next phase
  logic [LANES-1:0] cs_n_d, we_n_d;
  logic             oe_n_d, dq_oe_d, sel_phase;

  always_comb begin
    sel_phase = (state_d == ST_WSETUP) || (state_d == ST_WPULSE) ||
                (state_d == ST_WHOLD)  || (state_d == ST_RACC);
    cs_n_d    = sel_phase ? ~map_sel : '1;
    we_n_d    = (state_d == ST_WPULSE) ? ~map_wen : '1;
    oe_n_d    = (state_d != ST_RACC);
    dq_oe_d   = (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q     <= ST_IDLE;
      ack_q       <= 1'b0;
      mem_cs_n_o  <= '1;
      mem_we_n_o  <= '1;
      mem_oe_n_o  <= 1'b1;
      mem_dq_oe_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      ack_q       <= ack_d;
      mem_cs_n_o  <= cs_n_d;
      mem_we_n_o  <= we_n_d;
      mem_oe_n_o  <= oe_n_d;
      mem_dq_oe_o <= dq_oe_d;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      mem_addr_o <= map_addr;
      mem_dq_o   <= map_wdata;
    end
  end

  // Read data capture
  logic [DATA_W-1:0] rd_aligned, rdata_q;

  sram_rd_align #(.LANES(LANES), .BYTE_W(BYTE_W)) u_align (
    .mode  (mode_q),
    .bank  (addr_q[HOST_AW-1 -: 2]),
    .dq    (mem_dq_i),
    .rdata (rd_aligned)
  );

  always_ff @(posedge clk) begin
    if (rd_cap) rdata_q <= rd_aligned;
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;

  // R7: output enable stays high while any strobe is low
  p_oe_off_in_write_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!(&mem_we_n_o)) |-> mem_oe_n_o);

  // R7: never drive the bus while the memory may drive it
  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_dq_oe_o |-> mem_oe_n_o);

  // R5: a lane is strobed only while selected
  p_strobe_in_select_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((~mem_we_n_o & mem_cs_n_o) == '0));

  // R6: on strobe release, data and selects are held
  p_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|(mem_we_n_o & ~$past(mem_we_n_o))) |->
      (mem_dq_oe_o && $stable(mem_cs_n_o) && $stable(mem_dq_o)));

  // R9: acknowledge lasts one cycle
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    ack_o |=> !ack_o);

  // R10: turnaround after a read before any strobe
  p_turnaround_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(mem_oe_n_o) |=> (&mem_we_n_o));

  // R11: address stable while a lane stays selected
  p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!(&mem_cs_n_o) && !(&$past(mem_cs_n_o))) |-> $stable(mem_addr_o));

endmodule

// File: tb/sram_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        req_i, we_i;
  logic [20:0] addr_i;
  logic [31:0] wdata_i;
  logic [3:0]  be_i;
  logic        ack_o;
  logic [31:0] rdata_o;
  logic [18:0] mem_addr_o;
  logic [3:0]  mem_cs_n_o, mem_we_n_o;
  logic        mem_oe_n_o, mem_dq_oe_o;
  logic [31:0] mem_dq_o, mem_dq_i;

  always #10 clk = ~clk;

  sram_lane_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i), .ack_o(ack_o),
    .rdata_o(rdata_o), .mem_addr_o(mem_addr_o), .mem_cs_n_o(mem_cs_n_o),
    .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [7:0] dev   [int];
  logic [7:0] ref_m [int];
  logic [3:0] we_prev = 4'hF;

  function automatic logic [7:0] dflt(input int k);
    return 8'(k) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Memory model: stores on strobe rise, answers during read
  always @(negedge clk) begin
    for (int l = 0; l < 4; l++) begin
      int k;
      k = l * (1 << 19) + int'(mem_addr_o);
      if (!we_prev[l] && mem_we_n_o[l] && !mem_cs_n_o[l]) begin
        check(mem_dq_oe_o, "R7 data driven at write end", 32'(mem_dq_oe_o), 32'd1);
        dev[k] = mem_dq_o[l*8 +: 8];
      end
      if (!mem_cs_n_o[l] && !mem_oe_n_o && mem_we_n_o[l])
        mem_dq_i[l*8 +: 8] = dev.exists(k) ? dev[k] : dflt(k);
      else
        mem_dq_i[l*8 +: 8] = 8'h00;
    end
    we_prev = mem_we_n_o;
  end

  // Expected values from the requirements
  function automatic logic [3:0] exp_sel(input logic [1:0] m, input logic [20:0] a);
    if (m == 2'd0) return 4'hF;                  // R2
    if (m == 2'd1) return a[20] ? 4'hC : 4'h3;   // R3
    return 4'(1 << a[20:19]);                    // R4
  endfunction

  function automatic logic [3:0] exp_wen(input logic [1:0] m, input logic [20:0] a,
                                         input logic [3:0] be);
    logic [3:0] s, w;
    s = exp_sel(m, a);
    for (int l = 0; l < 4; l++)
      w[l] = s[l] & ((m == 2'd0) ? be[l] : (m == 2'd1) ? be[l%2] : be[0]);
    return w;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [1:0] m, input int l,
                                          input logic [31:0] d);
    if (m == 2'd0) return d[l*8 +: 8];
    if (m == 2'd1) return d[(l%2)*8 +: 8];
    return d[7:0];
  endfunction

  function automatic int exp_key(input logic [1:0] m, input logic [20:0] a, input int l);
    logic [18:0] la;
    if (m == 2'd0)      la = a[20:2];
    else if (m == 2'd1) la = a[19:1];
    else                la = a[18:0];
    return l * (1 << 19) + int'(la);
  endfunction

  function automatic logic [7:0] ref_rd(input int k);
    return ref_m.exists(k) ? ref_m[k] : dflt(k);
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [1:0] m, input logic [20:0] a);
    logic [31:0] r;
    int b;
    r = '0;
    if (m == 2'd0) begin
      for (int l = 0; l < 4; l++) r[l*8 +: 8] = ref_rd(exp_key(m, a, l));
    end else if (m == 2'd1) begin
      b = a[20] ? 2 : 0;
      r[7:0]  = ref_rd(exp_key(m, a, b));
      r[15:8] = ref_rd(exp_key(m, a, b + 1));
    end else begin
      r[7:0] = ref_rd(exp_key(m, a, int'(a[20:19])));
    end
    return r;
  endfunction

  int last_pre;

  task automatic do_op(input logic [1:0] m, input bit wr, input logic [20:0] a,
                       input logic [31:0] d, input logic [3:0] be,
                       input bit b2b, input bit tail);
    logic [3:0] cs_seen, we_seen;
    logic [31:0] rd_keep;
    bit oe_bad, started;
    int n, pre;
    if (!b2b) @(negedge clk);
    mode_i = m; we_i = wr; addr_i = a; wdata_i = d; be_i = be; req_i = 1'b1;
    cs_seen = '0; we_seen = '0; oe_bad = 0; started = 0; n = 0; pre = 0;
    forever begin
      @(negedge clk);
      n++;
      cs_seen |= ~mem_cs_n_o;
      we_seen |= ~mem_we_n_o;
      if (wr && !mem_oe_n_o) oe_bad = 1;
      if (!started && (&mem_cs_n_o)) pre++;
      else started = 1;
      if (ack_o || n > 40) break;
    end
    req_i = 1'b0;
    last_pre = pre;
    check(n <= 40, "R9 acknowledge arrives", 32'(n), 32'd40);
    check(cs_seen == exp_sel(m, a), "R2/R3/R4 selects for mode (R2 R3 R4)",
          32'(cs_seen), 32'(exp_sel(m, a)));
    if (wr) begin
      // R6: setup+pulse+hold = 3 cycles at 20 ns, plus the acknowledge cycle
      check(n - pre == 4, "R6 write latency", 32'(n - pre), 32'd4);
      check(we_seen == exp_wen(m, a, be), "R5 write strobes",
            32'(we_seen), 32'(exp_wen(m, a, be)));
      check(!oe_bad, "R7 output enable high in write", 32'(oe_bad), 32'd0);
      for (int l = 0; l < 4; l++)
        if (exp_wen(m, a, be)[l]) ref_m[exp_key(m, a, l)] = exp_byte(m, l, d);
    end else begin
      // R8: two access cycles at 20 ns, plus the acknowledge cycle
      check(n - pre == 3, "R8 read latency", 32'(n - pre), 32'd3);
      check(we_seen == 4'h0, "R8 no strobe in read", 32'(we_seen), 32'd0);
      check(rdata_o == exp_rdata(m, a), "R8 read data", rdata_o, exp_rdata(m, a));
    end
    if (tail) begin
      rd_keep = rdata_o;
      @(negedge clk);
      check(!ack_o, "R9 acknowledge single cycle", 32'(ack_o), 32'd0);
      if (!wr) check(rdata_o == rd_keep, "R9 read data held", rdata_o, rd_keep);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [20:0] a;
    rst_n = 1'b0; req_i = 1'b0; we_i = 1'b0; mode_i = 2'd0;
    addr_i = '0; wdata_i = '0; be_i = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(&mem_cs_n_o, "R1 selects idle in reset", 32'(mem_cs_n_o), 32'hF);
    check(&mem_we_n_o, "R1 strobes idle in reset", 32'(mem_we_n_o), 32'hF);
    check(mem_oe_n_o && !mem_dq_oe_o && !ack_o, "R1 enables idle in reset",
          {29'd0, mem_oe_n_o, mem_dq_oe_o, ack_o}, 32'h4);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check((&mem_cs_n_o) && (&mem_we_n_o) && mem_oe_n_o && !ack_o,
          "R1 idle after release", {mem_cs_n_o, mem_we_n_o}, 32'hFF);

    // R2: word write and read back, then partial-byte writes
    do_op(2'd0, 1, 21'h000100, 32'hA1B2C3D4, 4'hF, 0, 1);
    do_op(2'd0, 0, 21'h000100, 32'h0, 4'h0, 0, 1);
    do_op(2'd0, 1, 21'h000100, 32'h11223344, 4'b0100, 0, 1);
    do_op(2'd0, 1, 21'h000100, 32'h55667788, 4'b0011, 0, 1);
    do_op(2'd0, 0, 21'h000100, 32'h0, 4'h0, 0, 1);
    // R3: both half-word banks
    do_op(2'd1, 1, 21'h100008, 32'h0000BEEF, 4'b0011, 0, 1);
    do_op(2'd1, 1, 21'h000008, 32'h0000CAFE, 4'b0010, 0, 1);
    do_op(2'd1, 0, 21'h100008, 32'h0, 4'h0, 0, 1);
    do_op(2'd1, 0, 21'h000008, 32'h0, 4'h0, 0, 1);
    // R4: byte lanes 3 and 1, mode 3 as byte mode
    do_op(2'd2, 1, 21'h180004, 32'h000000E7, 4'b0001, 0, 1);
    do_op(2'd3, 1, 21'h080004, 32'h0000003C, 4'b0001, 0, 1);
    do_op(2'd2, 0, 21'h180004, 32'h0, 4'h0, 0, 1);
    do_op(2'd3, 0, 21'h080004, 32'h0, 4'h0, 0, 1);
    // R5: byte write with strobe 0 clear leaves contents unchanged
    do_op(2'd2, 1, 21'h180004, 32'h000000FF, 4'b1110, 0, 1);
    do_op(2'd2, 0, 21'h180004, 32'h0, 4'h0, 0, 1);
    r = rdata_o;
    check(r[7:0] == 8'hE7, "R5 ignored write left byte", r, 32'hE7);
    // R10: write requested right at a read's acknowledge waits for turnaround
    do_op(2'd0, 0, 21'h000200, 32'h0, 4'h0, 0, 0);
    do_op(2'd0, 1, 21'h000200, 32'h0F0E0D0C, 4'hF, 1, 1);
    check(last_pre >= 1, "R10 turnaround before write", 32'(last_pre), 32'd1);

    // Random mix over a small window
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      a  = {rv[20:19], 13'd0, rv[5:0]};
      do_op(rv[27:26], rv[28], a, $urandom, rv[31:28], 0, rv[29]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule